// File: doc/BRIEF.md
# Microcontroller Reset Sequencer and Classifier

This block gathers every reason a small microcontroller may need to restart and turns them into one chip reset, synchronous to the main oscillator clock. Four sources are handled: power-on (an asynchronous active-low input), an external active-low clear pin, a watchdog timeout and a brown-out detector. Once the last request goes away, two delays run in series. A power-up delay is counted in edges of a slow internal clock. An oscillator start-up delay is then counted in main-clock cycles. The chip reset drops only when both have finished.

Alongside the reset, the block records the kind of the most recent event and keeps two status flags, a timeout flag and a power-down flag, that software reads to tell the events apart. A watchdog timeout while the core sleeps is not treated as a reset. It produces a single-cycle wake-up pulse, so execution resumes with registers intact. The clear pin is filtered, so short glitches never restart the chip. The brown-out request counts only when both its configuration enable and its run-time enable are set.

Top module: `mcu_reset_seq`

## Requirements
- R1: While `por_n` is low, `chip_rst` is 1, `rst_kind` is 1, `to_flag` is 1, `pd_flag` is 1 and `wake_o` is 0.
- R2: After the last reset request is removed, the power-up delay lasts 2^PWRT_W rising edges of `lf_clk`. The start-up delay that follows lasts 2^OST_W clock cycles. Only then does `chip_rst` fall.
- R3: A delay whose enable (`pwrt_en`, `ost_en`) is 0 counts as already expired. With both disabled, `chip_rst` falls three cycles after the request edge.
- R4: A new reset request that arrives while a delay is running restarts the whole sequence from the hold state.
- R5: `mclr_n` raises a reset only after 4 consecutive low samples from its two-stage synchronizer. A low pulse of 3 clock cycles has no effect.
- R6: `bor_detect` raises a reset only while `bor_cfg_en` and `bor_sw_en` are both 1. With either enable at 0 it is ignored.
- R7: A `wdt_timeout` pulse while running and awake resets the chip, sets `rst_kind` to 2 and clears `to_flag`. `pd_flag` is left unchanged.
- R8: A `wdt_timeout` pulse while running and asleep leaves `chip_rst` at 0. In the next cycle it raises `wake_o` for exactly one cycle, sets `rst_kind` to 3 and clears `to_flag`.
- R9: A filtered clear sets `rst_kind` to 4 when `sleep_i` is 0 and to 5 when `sleep_i` is 1. `to_flag` and `pd_flag` are not changed.
- R10: A brown-out reset sets `rst_kind` to 6 and sets both `to_flag` and `pd_flag` to 1.
- R11: A rising edge of `sleep_i` while `chip_rst` is 0 clears `pd_flag` and leaves `to_flag` unchanged.
- R12: When events coincide in one cycle, the recorded kind and the flag updates follow the priority brown-out, then watchdog, then clear pin.
- R13: `wdt_timeout` is ignored while `chip_rst` is 1. It does not restart the sequence, does not pulse `wake_o` and does not touch the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| lf_clk | input | 1 | Low-frequency internal clock, sampled as a tick source |
| mclr_n | input | 1 | External clear pin, raw, active low |
| wdt_timeout | input | 1 | Watchdog timeout pulse, synchronous |
| bor_detect | input | 1 | Brown-out detector output, synchronous, active high |
| bor_cfg_en | input | 1 | Brown-out configuration enable |
| bor_sw_en | input | 1 | Brown-out run-time enable |
| sleep_i | input | 1 | Core is in sleep |
| pwrt_en | input | 1 | Power-up delay enable |
| ost_en | input | 1 | Oscillator start-up delay enable |
| chip_rst | output | 1 | Synchronous chip reset, active high |
| wake_o | output | 1 | One-cycle wake-up pulse for a watchdog timeout in sleep |
| rst_kind | output | 3 | Last event: 1 power-on, 2 watchdog run, 3 watchdog sleep, 4 clear run, 5 clear sleep, 6 brown-out |
| to_flag | output | 1 | Timeout status flag |
| pd_flag | output | 1 | Power-down status flag |

## Verification
Two overlaps get dedicated stimulus. In the first, a brown-out and a watchdog timeout are driven in the same cycle: the recorded kind must be brown-out with both flags set, and the release time must match one single restart. In the second, a brown-out pulse lands in the middle of the start-up delay that follows a watchdog reset, and a stray watchdog pulse is injected during another hold. The bench then measures the number of cycles `chip_rst` stays high against the restart and ignore rules, and the scoreboard confirms that exactly one release is seen per expected event.

// File: rtl/mcu_rst_pkg.sv
package mcu_rst_pkg;

  typedef enum logic [1:0] {
    SEQ_HOLD = 2'd0,
    SEQ_PWRT = 2'd1,
    SEQ_OST  = 2'd2,
    SEQ_RUN  = 2'd3
  } seq_state_e;

  typedef enum logic [2:0] {
    KIND_NONE       = 3'd0,
    KIND_POWER_ON   = 3'd1,
    KIND_WDT_RUN    = 3'd2,
    KIND_WDT_SLEEP  = 3'd3,
    KIND_CLR_RUN    = 3'd4,
    KIND_CLR_SLEEP  = 3'd5,
    KIND_BROWN_OUT  = 3'd6
  } rst_kind_e;

endpackage

// File: rtl/mcu_rst_sync.sv
// Multi-stage synchronizer with a selectable reset value.
module mcu_rst_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= {STAGES{RST_VAL}};
    end else begin
      sh_q <= sh_d;
    end
  end

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/mcu_rst_filter.sv
// Glitch filter for the external clear pin: synchronizer plus a
// run-length counter of consecutive low samples.
module mcu_rst_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_i,
  output logic act_o
);

  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic          pin_s;
  logic [CW-1:0] run_q, run_d;
  logic          act_q, act_d;

  mcu_rst_sync #(.STAGES(2), .RST_VAL(1'b1)) i_pin_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_n_i),
    .q_o   (pin_s)
  );

  always_comb begin
    if (pin_s) begin
      run_d = '0;
      act_d = 1'b0;
    end else begin
      act_d = act_q | (run_q == LAST);
      run_d = (run_q == LAST) ? run_q : run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      act_q <= 1'b0;
    end else begin
      run_q <= run_d;
      act_q <= act_d;
    end
  end

  assign act_o = act_q;

endmodule

// File: rtl/mcu_rst_timer.sv
// Delay counter: counts 2**W ticks while run_i is high.
// A disabled counter reports done as soon as it runs.
module mcu_rst_timer #(
  parameter int W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic en_i,
  input  logic tick_i,
  output logic done_o
);

  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_ce;

  assign cnt_ce = ~run_i | (en_i & tick_i);

  always_comb begin
    if (!run_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign done_o = run_i & (~en_i | (tick_i & (cnt_q == CNT_MAX)));

endmodule

// File: rtl/mcu_reset_seq.sv
// Reset sequencer and classifier for a small microcontroller.
module mcu_reset_seq
  import mcu_rst_pkg::*;
#(
  parameter int PWRT_W   = 11,
  parameter int OST_W    = 10,
  parameter int FILT_LEN = 4
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       lf_clk,
  input  logic       mclr_n,
  input  logic       wdt_timeout,
  input  logic       bor_detect,
  input  logic       bor_cfg_en,
  input  logic       bor_sw_en,
  input  logic       sleep_i,
  input  logic       pwrt_en,
  input  logic       ost_en,
  output logic       chip_rst,
  output logic       wake_o,
  output logic [2:0] rst_kind,
  output logic       to_flag,
  output logic       pd_flag
);

  // power-on reset, released synchronously
  logic rst_n;

  mcu_rst_sync #(.STAGES(2), .RST_VAL(1'b0)) i_por_sync (
    .clk   (clk),
    .rst_n (por_n),
    .d_i   (1'b1),
    .q_o   (rst_n)
  );

  // low-frequency clock turned into a one-cycle tick
  logic lf_s, lf_q, lf_tick;

  mcu_rst_sync #(.STAGES(2), .RST_VAL(1'b0)) i_lf_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (lf_clk),
    .q_o   (lf_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lf_q <= 1'b0;
    end else begin
      lf_q <= lf_s;
    end
  end

  assign lf_tick = lf_s & ~lf_q;

  // filtered external clear
  logic mclr_act;

  mcu_rst_filter #(.FILT_LEN(FILT_LEN)) i_clr_filter (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_n_i (mclr_n),
    .act_o   (mclr_act)
  );

  // request decode
  seq_state_e seq_state, seq_state_d;
  logic       running;
  logic       bor_req;
  logic       wdt_hit;
  logic       wdt_req;
  logic       any_req;

  assign running  = (seq_state == SEQ_RUN);
  assign bor_req  = bor_detect & bor_cfg_en & bor_sw_en;
  assign wdt_hit  = wdt_timeout & running;
  assign wdt_req  = wdt_hit & ~sleep_i;
  assign any_req  = bor_req | wdt_req | mclr_act;

  // delay chain
  logic pwrt_done, ost_done;

  mcu_rst_timer #(.W(PWRT_W)) i_pwrt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (seq_state == SEQ_PWRT),
    .en_i   (pwrt_en),
    .tick_i (lf_tick),
    .done_o (pwrt_done)
  );

  mcu_rst_timer #(.W(OST_W)) i_ost (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (seq_state == SEQ_OST),
    .en_i   (ost_en),
    .tick_i (1'b1),
    .done_o (ost_done)
  );

  // sequence next state
  always_comb begin
    seq_state_d = seq_state;
    unique case (seq_state)
      SEQ_HOLD: seq_state_d = SEQ_PWRT;
      SEQ_PWRT: if (pwrt_done) seq_state_d = SEQ_OST;
      SEQ_OST:  if (ost_done)  seq_state_d = SEQ_RUN;
      SEQ_RUN:  seq_state_d = SEQ_RUN;
      default:  seq_state_d = SEQ_HOLD;
    endcase
    if (any_req) begin
      seq_state_d = SEQ_HOLD;
    end
  end

  // classification and status flags
  logic      sleep_q, mclr_q;
  rst_kind_e kind_q, kind_d;
  logic      to_q, to_d, pd_q, pd_d, wake_q, wake_d;

  always_comb begin
    kind_d = kind_q;
    to_d   = to_q;
    pd_d   = pd_q;
    wake_d = 1'b0;
    // lowest priority first, later statements override
    if (sleep_i && !sleep_q && running) begin
      pd_d = 1'b0;
    end
    if (mclr_act && !mclr_q) begin
      kind_d = sleep_i ? KIND_CLR_SLEEP : KIND_CLR_RUN;
    end
    if (wdt_hit) begin
      to_d   = 1'b0;
      kind_d = sleep_i ? KIND_WDT_SLEEP : KIND_WDT_RUN;
      wake_d = sleep_i;
    end
    if (bor_req) begin
      kind_d = KIND_BROWN_OUT;
      to_d   = 1'b1;
      pd_d   = 1'b1;
      wake_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_state <= SEQ_HOLD;
      kind_q    <= KIND_POWER_ON;
      to_q      <= 1'b1;
      pd_q      <= 1'b1;
      wake_q    <= 1'b0;
      sleep_q   <= 1'b0;
      mclr_q    <= 1'b0;
    end else begin
      seq_state <= seq_state_d;
      kind_q    <= kind_d;
      to_q      <= to_d;
      pd_q      <= pd_d;
      wake_q    <= wake_d;
      sleep_q   <= sleep_i;
      mclr_q    <= mclr_act;
    end
  end

  assign chip_rst = ~running;
  assign wake_o   = wake_q;
  assign rst_kind = kind_q;
  assign to_flag  = to_q;
  assign pd_flag  = pd_q;

endmodule

// File: rtl/mcu_reset_seq_chk.sv
module mcu_reset_seq_chk
  import mcu_rst_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       chip_rst,
  input logic       wake_o,
  input logic [2:0] rst_kind,
  input logic       to_flag,
  input logic       pd_flag,
  input logic       wdt_timeout,
  input logic       sleep_i,
  input logic       bor_req,
  input logic       mclr_act,
  input seq_state_e seq_state
);

  p_bor_marks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bor_req |=> (chip_rst && rst_kind == 3'd6 && to_flag && pd_flag));

  p_bor_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bor_req && wdt_timeout) |=> (rst_kind == 3'd6 && to_flag));

  p_wdt_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_timeout && !sleep_i && !chip_rst && !bor_req) |=> (chip_rst && !to_flag));

  p_wdt_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_timeout && sleep_i && !chip_rst && !bor_req && !mclr_act) |=> (wake_o && !chip_rst));

  p_wake_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(wdt_timeout && sleep_i));

  p_wdt_in_reset_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_timeout && chip_rst && !bor_req) |=> (!wake_o && to_flag == $past(to_flag)));

  p_clear_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mclr_act |=> chip_rst);

  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chip_rst) |-> ($past(seq_state) == SEQ_OST));

  p_sleep_pd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sleep_i) && !chip_rst && !bor_req) |=> !pd_flag);

endmodule

bind mcu_reset_seq mcu_reset_seq_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .chip_rst    (chip_rst),
  .wake_o      (wake_o),
  .rst_kind    (rst_kind),
  .to_flag     (to_flag),
  .pd_flag     (pd_flag),
  .wdt_timeout (wdt_timeout),
  .sleep_i     (sleep_i),
  .bor_req     (bor_req),
  .mclr_act    (mclr_act),
  .seq_state   (seq_state)
);

// File: tb/test_mcu_reset_seq.sv
module test_mcu_reset_seq;

  localparam int CLK_P    = 10;
  localparam int LF_HALF  = 4;      // clk periods per lf_clk half period
  localparam int PWRT_W   = 3;
  localparam int OST_W    = 4;
  localparam int WD_LIMIT = 50000;

  logic       clk = 1'b0;
  logic       lf_clk = 1'b0;
  logic       por_n, mclr_n, wdt_timeout, bor_detect, bor_cfg_en, bor_sw_en;
  logic       sleep_i, pwrt_en, ost_en;
  logic       chip_rst, wake_o, to_flag, pd_flag;
  logic [2:0] rst_kind;

  always #(CLK_P/2) clk = ~clk;
  always #(CLK_P*LF_HALF) lf_clk = ~lf_clk;

  mcu_reset_seq #(.PWRT_W(PWRT_W), .OST_W(OST_W), .FILT_LEN(4)) i_mcu_reset_seq (
    .clk         (clk),
    .por_n       (por_n),
    .lf_clk      (lf_clk),
    .mclr_n      (mclr_n),
    .wdt_timeout (wdt_timeout),
    .bor_detect  (bor_detect),
    .bor_cfg_en  (bor_cfg_en),
    .bor_sw_en   (bor_sw_en),
    .sleep_i     (sleep_i),
    .pwrt_en     (pwrt_en),
    .ost_en      (ost_en),
    .chip_rst    (chip_rst),
    .wake_o      (wake_o),
    .rst_kind    (rst_kind),
    .to_flag     (to_flag),
    .pd_flag     (pd_flag)
  );

  typedef struct {
    int    kind;
    int    to;
    int    pd;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int   total = 0;
  int   bad   = 0;
  bit   mon_en = 1'b0;
  logic prev_rst = 1'b1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_win(input string tag, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic push(input int k, input int t, input int p, input string tag);
    exp_t e;
    e.kind = k; e.to = t; e.pd = p; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: a release or a wake-up completes one expected event
  always @(negedge clk) begin
    if (mon_en && ((prev_rst && !chip_rst) || wake_o)) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "unexpected release or wake", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(rst_kind == 3'(e.kind), {e.tag, " kind"}, rst_kind, e.kind);
        chk(to_flag == 1'(e.to), {e.tag, " to_flag"}, to_flag, e.to);
        chk(pd_flag == 1'(e.pd), {e.tag, " pd_flag"}, pd_flag, e.pd);
      end
    end
    prev_rst = chip_rst;
  end

  task automatic count_hold(output int n);
    n = 0;
    while (chip_rst) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_wdt();
    wdt_timeout = 1'b1;
    @(negedge clk);
    wdt_timeout = 1'b0;
  endtask

  task automatic run_all();
    int n;
    por_n = 1'b0; mclr_n = 1'b1; wdt_timeout = 1'b0; bor_detect = 1'b0;
    bor_cfg_en = 1'b1; bor_sw_en = 1'b0; sleep_i = 1'b0;
    pwrt_en = 1'b1; ost_en = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(chip_rst == 1'b1, "R1 chip_rst", chip_rst, 1);
    chk(rst_kind == 3'd1, "R1 kind", rst_kind, 1);
    chk(to_flag == 1'b1 && pd_flag == 1'b1, "R1 flags", {to_flag, pd_flag}, 3);
    chk(wake_o == 1'b0, "R1 wake", wake_o, 0);

    // R2 full sequence after power-on
    push(1, 1, 1, "R1 release");
    mon_en = 1'b1;
    por_n = 1'b1;
    count_hold(n);
    chk_win("R2 power-on hold cycles", n, 72, 88);

    // R11 sleep entry
    sleep_i = 1'b1;
    @(negedge clk);
    chk(pd_flag == 1'b0 && to_flag == 1'b1, "R11 sleep entry flags", {to_flag, pd_flag}, 2);

    // R8 watchdog in sleep
    push(3, 0, 0, "R8 wake");
    pulse_wdt();
    chk(chip_rst == 1'b0 && wake_o == 1'b1, "R8 wake without reset", {chip_rst, wake_o}, 1);
    @(negedge clk);
    chk(wake_o == 1'b0, "R8 single-cycle wake", wake_o, 0);
    sleep_i = 1'b0;
    @(negedge clk);

    // R7 watchdog while running, plus R13 ignored watchdog during hold
    pwrt_en = 1'b0;
    push(2, 0, 0, "R7 watchdog run");
    pulse_wdt();
    n = 0;
    while (chip_rst) begin
      n++;
      wdt_timeout = (n == 4);
      @(negedge clk);
    end
    wdt_timeout = 1'b0;
    chk_win("R13 hold with ignored watchdog", n, 17, 19);

    // R3 both delays disabled
    ost_en = 1'b0;
    push(2, 0, 0, "R3 watchdog run");
    pulse_wdt();
    count_hold(n);
    chk_win("R3 hold cycles, delays disabled", n, 2, 4);

    // R6 brown-out ignored without run-time enable
    bor_detect = 1'b1;
    repeat (5) begin
      @(negedge clk);
      chk(chip_rst == 1'b0, "R6 gated brown-out", chip_rst, 0);
    end
    chk(rst_kind == 3'd2, "R6 kind unchanged", rst_kind, 2);
    bor_detect = 1'b0;

    // R10 brown-out with power-up delay only
    pwrt_en = 1'b1;
    bor_sw_en = 1'b1;
    push(6, 1, 1, "R10 brown-out");
    bor_detect = 1'b1;
    repeat (3) @(negedge clk);
    chk(chip_rst == 1'b1, "R6 enabled brown-out", chip_rst, 1);
    bor_detect = 1'b0;
    count_hold(n);
    chk_win("R2 power-up delay only", n, 57, 68);

    // R5 short clear pulse ignored
    pwrt_en = 1'b0;
    ost_en = 1'b1;
    mclr_n = 1'b0;
    repeat (3) @(negedge clk);
    mclr_n = 1'b1;
    repeat (8) begin
      @(negedge clk);
      chk(chip_rst == 1'b0, "R5 glitch ignored", chip_rst, 0);
    end

    // R9 clear while running
    push(4, 1, 1, "R9 clear run");
    mclr_n = 1'b0;
    repeat (7) @(negedge clk);
    chk(chip_rst == 1'b1, "R5 long clear", chip_rst, 1);
    mclr_n = 1'b1;
    count_hold(n);
    chk_win("R5 clear release cycles", n, 20, 22);

    // R9 clear while asleep
    sleep_i = 1'b1;
    @(negedge clk);
    push(5, 1, 0, "R9 clear sleep");
    mclr_n = 1'b0;
    repeat (7) @(negedge clk);
    sleep_i = 1'b0;
    mclr_n = 1'b1;
    count_hold(n);
    chk_win("R9 clear sleep release", n, 20, 22);

    // R12 brown-out and watchdog in the same cycle
    push(6, 1, 1, "R12 coincident");
    bor_detect = 1'b1;
    wdt_timeout = 1'b1;
    @(negedge clk);
    bor_detect = 1'b0;
    wdt_timeout = 1'b0;
    count_hold(n);
    chk_win("R12 single restart", n, 17, 19);

    // R4 restart in the middle of the start-up delay
    push(6, 1, 1, "R4 restart");
    pulse_wdt();
    n = 0;
    repeat (8) begin
      if (chip_rst) n++;
      @(negedge clk);
    end
    chk(n == 8, "R4 held before restart", n, 8);
    bor_detect = 1'b1;
    @(negedge clk);
    bor_detect = 1'b0;
    count_hold(n);
    chk_win("R4 hold after restart", n, 17, 19);

    repeat (4) @(negedge clk);
    chk(sb_q.size() == 0, "all expected events observed", sb_q.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (WD_LIMIT) @(posedge clk);
        chk(1'b0, "watchdog expired", WD_LIMIT, 0);
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule